// File: doc/BRIEF.md
# Paired-Word SEC-DED Memory Controller

This controller sits between a host port and two 32-bit memory lanes built from ordinary byte-parity modules. The two lanes act as one matched pair and together hold one 64-bit word. Each lane has four spare bits that would normally hold byte parity. In the protected mode, those eight bits carry the eight check bits of an extended Hamming (72,64) code. Every write drives both lanes in one memory access. Every read is decoded: a single flipped bit is repaired in the same access, and a double flip is reported as uncorrectable.

Corrections are logged in a counter and an address register. A double-bit failure retires the whole matched pair that holds the word. From then on, any request to that pair is refused without a memory access. When the mode input is low, the controller drops back to plain even parity, one bit per byte on each lane. A parity mismatch then raises a non-maskable error pulse and nothing is corrected.

A write that does not cover all eight bytes is done as a read-modify-write of the whole word, so the check bits always match the stored data.

Top module: `paired_ecc_ctrl`

## Requirements
- R1: With `ecc_mode` high, a full write (`host_be` = 8'hFF) issues exactly one memory write. Data bits [31:0] go on the low lane and [63:32] on the high lane. The code places data bit j at the j-th position in 1..71 that is not a power of two, counting upward. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6. The low lane's check pins carry check[3:0] and the high lane's carry check[7:4].
- R2: A clean read in ECC mode returns the stored 64-bit word with no flag raised. `rd_valid` is high for exactly the cycle after the one in which `mem_rvalid` is high.
- R3: A single flipped data bit is corrected: `rd_data` holds the original word and `rd_corrected` pulses together with `rd_valid`.
- R4: A single flipped check bit, including the overall bit 7, gives `rd_corrected` and returns the data unchanged.
- R5: Each correction, whether from a read or from the read phase of a partial write, increments `corr_count` by one and loads `corr_addr` with the word address.
- R6: Two flipped bits in one word raise `rd_uncorrectable` with `rd_valid`, without `rd_corrected`, and leave `corr_count` unchanged.
- R7: An uncorrectable error sets the bit of `pair_retired` selected by the top log2(PAIRS) address bits, and the bit stays set until reset. Any later request to that pair gives a one-cycle `req_refused` in the cycle after the request, with no memory access and no `rd_valid`. Other pairs keep working.
- R8: A partial write reads the word, corrects it, replaces the bytes whose `host_be` bit is 1, and writes back the full word with freshly computed check bits.
- R9: With `ecc_mode` low, the bit of lane check pin k is the XOR of byte k of that lane (even parity). A read with a mismatch pulses `parity_nmi` with `rd_valid`, returns the data as read, and changes neither `corr_count` nor `rd_corrected`.
- R10: After reset, `host_ready` is high, `corr_count` is zero, `pair_retired` is all zeros, and `rd_valid`, `req_refused` and `mem_req` are low.
- R11: A partial write whose read phase finds an uncorrectable error issues no memory write, pulses `rd_uncorrectable` without `rd_valid`, and retires the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_mode | input | 1 | 1 = paired SEC-DED, 0 = byte parity; sampled when a request is accepted |
| host_req | input | 1 | Request strobe, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address; top log2(PAIRS) bits select the matched pair |
| host_be | input | 8 | Byte enables for writes |
| host_wdata | input | 64 | Write data |
| host_ready | output | 1 | Controller idle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data, corrected in ECC mode |
| rd_corrected | output | 1 | Single-bit error repaired on this read |
| rd_uncorrectable | output | 1 | Double-bit error found |
| parity_nmi | output | 1 | Parity mismatch in parity mode |
| req_refused | output | 1 | Request aimed at a retired pair |
| corr_count | output | CNT_W | Number of corrected errors |
| corr_addr | output | ADDR_W | Address of the latest correction |
| pair_retired | output | PAIRS | Retired pair flags |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | ADDR_W | Memory word address |
| mem_lo_data | output | 32 | Low lane write data |
| mem_lo_chk | output | 4 | Low lane check/parity write bits |
| mem_hi_data | output | 32 | High lane write data |
| mem_hi_chk | output | 4 | High lane check/parity write bits |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_lo_rdata | input | 32 | Low lane read data |
| mem_lo_rchk | input | 4 | Low lane check/parity read bits |
| mem_hi_rdata | input | 32 | High lane read data |
| mem_hi_rchk | input | 4 | High lane check/parity read bits |

## Verification
The bench injects faults at both ends of the data word (bit 0 and bit 63), in a low-lane check bit and in the overall parity bit. A decoder with a wrong position map, or one that treats a check-bit hit as a data hit, would return altered data or flag the word as uncorrectable. It then retires a pair and probes the same pair at a different address and a healthy pair. Retirement indexed by the wrong address bits would refuse the wrong pair or still touch memory. Partial writes are driven over a word with a stored single error and over one with a double error. A design that merged the uncorrected read data, or wrote back after a failed read, would leave the stored word or the write count wrong. In parity mode the bench checks the stored parity pins and a mismatching read, which catches odd parity or a stray correction.

// File: rtl/paired_ecc_pkg.sv
package paired_ecc_pkg;

  localparam int WORD_W = 64;
  localparam int LANE_W = 32;
  localparam int CHK_W  = 8;
  localparam int SYN_W  = 7;
  localparam int BYTES  = WORD_W / 8;

  typedef struct packed {
    logic [3:0]        hi_chk;
    logic [LANE_W-1:0] hi_data;
    logic [3:0]        lo_chk;
    logic [LANE_W-1:0] lo_data;
  } mem_word_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_WAIT, S_RD_DEC, S_RMW_WAIT, S_RMW_MERGE
  } ctrl_state_e;

  // Hamming position of data bit j: the j-th non power of two in 1..71.
  function automatic logic [SYN_W-1:0] data_pos(input int j);
    logic [SYN_W-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (k == j) r = SYN_W'(p);
        k++;
      end
    end
    return r;
  endfunction

  // Seven Hamming bits plus overall parity in bit 7.
  function automatic logic [CHK_W-1:0] secded_check(input logic [WORD_W-1:0] d);
    logic [SYN_W-1:0] c;
    logic [SYN_W-1:0] p;
    c = '0;
    for (int j = 0; j < WORD_W; j++) begin
      p = data_pos(j);
      for (int i = 0; i < SYN_W; i++)
        if (p[i]) c[i] = c[i] ^ d[j];
    end
    return {(^d) ^ (^c), c};
  endfunction

  function automatic logic [3:0] lane_parity(input logic [LANE_W-1:0] w);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = ^w[8*b +: 8];
    return r;
  endfunction

endpackage

// File: rtl/ecc_word_encode.sv
module ecc_word_encode
  import paired_ecc_pkg::*;
(
  input  logic [WORD_W-1:0] data_in,
  input  logic              ecc_en,
  output mem_word_t         word_out
);
  logic [CHK_W-1:0] chk;

  always_comb begin
    chk = secded_check(data_in);
    word_out.lo_data = data_in[LANE_W-1:0];
    word_out.hi_data = data_in[WORD_W-1:LANE_W];
    if (ecc_en) begin
      word_out.lo_chk = chk[3:0];
      word_out.hi_chk = chk[7:4];
    end else begin
      word_out.lo_chk = lane_parity(data_in[LANE_W-1:0]);
      word_out.hi_chk = lane_parity(data_in[WORD_W-1:LANE_W]);
    end
  end
endmodule

// File: rtl/ecc_word_decode.sv
module ecc_word_decode
  import paired_ecc_pkg::*;
(
  input  mem_word_t         word_in,
  input  logic              ecc_en,
  output logic [WORD_W-1:0] data_out,
  output logic              corrected,
  output logic              uncorrectable,
  output logic              parity_err
);
  logic [WORD_W-1:0] raw;
  logic [CHK_W-1:0]  rchk;
  logic [CHK_W-1:0]  cchk;
  logic [SYN_W-1:0]  syn;
  logic              odd;
  logic              hit;

  always_comb begin
    raw  = {word_in.hi_data, word_in.lo_data};
    rchk = {word_in.hi_chk, word_in.lo_chk};
    cchk = secded_check(raw);
    syn  = cchk[SYN_W-1:0] ^ rchk[SYN_W-1:0];
    odd  = ^{raw, rchk};
    data_out      = raw;
    corrected     = 1'b0;
    uncorrectable = 1'b0;
    parity_err    = 1'b0;
    hit           = 1'b0;
    if (ecc_en) begin
      if (odd) begin
        if ($countones(syn) <= 1) begin
          corrected = 1'b1;             // check bit only
        end else begin
          for (int j = 0; j < WORD_W; j++) begin
            if (syn == data_pos(j)) begin
              data_out[j] = ~raw[j];
              hit = 1'b1;
            end
          end
          corrected     = hit;
          uncorrectable = ~hit;         // syndrome beyond last position
        end
      end else if (syn != '0) begin
        uncorrectable = 1'b1;
      end
    end else begin
      parity_err = (lane_parity(word_in.lo_data) != word_in.lo_chk) ||
                   (lane_parity(word_in.hi_data) != word_in.hi_chk);
    end
  end
endmodule

// File: rtl/pair_retire_table.sv
module pair_retire_table #(
  parameter int PAIRS = 4,
  localparam int IDX_W = $clog2(PAIRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_en,
  input  logic [IDX_W-1:0] retire_idx,
  input  logic [IDX_W-1:0] query_idx,
  output logic             query_hit,
  output logic [PAIRS-1:0] retired
);
  always_ff @(posedge clk) begin
    if (!rst_n) retired <= '0;
    else if (retire_en) retired[retire_idx] <= 1'b1;
  end

  assign query_hit = retired[query_idx];

  // R7: a retired pair never comes back before reset
  p_retire_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retired != '0) |=> ((retired & $past(retired)) == $past(retired)));

  // R7: new retirement only follows a retire request
  p_retire_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retired != $past(retired)) |-> $past(retire_en));
endmodule

// File: rtl/paired_ecc_ctrl.sv
module paired_ecc_ctrl
  import paired_ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAIRS  = 4,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(PAIRS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_mode,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_be,
  input  logic [63:0]       host_wdata,
  output logic              host_ready,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable,
  output logic              parity_nmi,
  output logic              req_refused,
  output logic [CNT_W-1:0]  corr_count,
  output logic [ADDR_W-1:0] corr_addr,
  output logic [PAIRS-1:0]  pair_retired,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_lo_data,
  output logic [3:0]        mem_lo_chk,
  output logic [31:0]       mem_hi_data,
  output logic [3:0]        mem_hi_chk,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_lo_rdata,
  input  logic [3:0]        mem_lo_rchk,
  input  logic [31:0]       mem_hi_rdata,
  input  logic [3:0]        mem_hi_rchk
);
  ctrl_state_e       state;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic [WORD_W-1:0] wdata_q;
  logic              mode_q;
  mem_word_t         raw_q;
  mem_word_t         rd_word;
  mem_word_t         enc_word;
  mem_word_t         wr_q;
  logic              mem_req_q, mem_we_q, refused_q;
  logic [ADDR_W-1:0] mem_addr_q;

  logic [WORD_W-1:0] dec_data;
  logic              dec_corr, dec_unc, dec_par;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] wr_src;
  logic              wr_mode;
  logic              pair_hit;

  // named internal events
  logic dec_active, corr_event, ded_event, par_event, rmw_write;

  assign rd_word.lo_data = mem_lo_rdata;
  assign rd_word.lo_chk  = mem_lo_rchk;
  assign rd_word.hi_data = mem_hi_rdata;
  assign rd_word.hi_chk  = mem_hi_rchk;

  ecc_word_decode u_dec (
    .word_in(raw_q), .ecc_en(mode_q), .data_out(dec_data),
    .corrected(dec_corr), .uncorrectable(dec_unc), .parity_err(dec_par)
  );

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign wr_src  = (state == S_RMW_MERGE) ? merged : host_wdata;
  assign wr_mode = (state == S_RMW_MERGE) ? mode_q : ecc_mode;

  ecc_word_encode u_enc (.data_in(wr_src), .ecc_en(wr_mode), .word_out(enc_word));

  pair_retire_table #(.PAIRS(PAIRS)) u_retire (
    .clk(clk), .rst_n(rst_n),
    .retire_en(ded_event), .retire_idx(addr_q[ADDR_W-1 -: IDX_W]),
    .query_idx(host_addr[ADDR_W-1 -: IDX_W]), .query_hit(pair_hit),
    .retired(pair_retired)
  );

  assign dec_active = (state == S_RD_DEC) || (state == S_RMW_MERGE);
  assign corr_event = dec_active && dec_corr;
  assign ded_event  = dec_active && dec_unc;
  assign par_event  = dec_active && dec_par;
  assign rmw_write  = (state == S_RMW_MERGE) && !dec_unc && !dec_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      addr_q     <= '0;
      be_q       <= '0;
      wdata_q    <= '0;
      mode_q     <= 1'b0;
      raw_q      <= '0;
      wr_q       <= '0;
      mem_req_q  <= 1'b0;
      mem_we_q   <= 1'b0;
      mem_addr_q <= '0;
      refused_q  <= 1'b0;
    end else begin
      mem_req_q <= 1'b0;
      refused_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (host_req) begin
            if (pair_hit) begin
              refused_q <= 1'b1;
            end else begin
              addr_q     <= host_addr;
              be_q       <= host_be;
              wdata_q    <= host_wdata;
              mode_q     <= ecc_mode;
              mem_addr_q <= host_addr;
              mem_req_q  <= 1'b1;
              if (host_we && (host_be == '1)) begin
                mem_we_q <= 1'b1;
                wr_q     <= enc_word;
              end else begin
                mem_we_q <= 1'b0;
                state    <= host_we ? S_RMW_WAIT : S_RD_WAIT;
              end
            end
          end
        end
        S_RD_WAIT: if (mem_rvalid) begin
          raw_q <= rd_word;
          state <= S_RD_DEC;
        end
        S_RMW_WAIT: if (mem_rvalid) begin
          raw_q <= rd_word;
          state <= S_RMW_MERGE;
        end
        S_RD_DEC: state <= S_IDLE;
        S_RMW_MERGE: begin
          state <= S_IDLE;
          if (rmw_write) begin
            mem_req_q <= 1'b1;
            mem_we_q  <= 1'b1;
            wr_q      <= enc_word;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // correction log
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_count <= '0;
      corr_addr  <= '0;
    end else if (corr_event) begin
      corr_addr <= addr_q;
      if (corr_count != '1) corr_count <= corr_count + 1'b1;
    end
  end

  assign host_ready       = (state == S_IDLE);
  assign rd_valid         = (state == S_RD_DEC);
  assign rd_data          = dec_data;
  assign rd_corrected     = (state == S_RD_DEC) && dec_corr;
  assign rd_uncorrectable = ded_event;
  assign parity_nmi       = par_event;
  assign req_refused      = refused_q;
  assign mem_req          = mem_req_q;
  assign mem_we           = mem_we_q;
  assign mem_addr         = mem_addr_q;
  assign mem_lo_data      = wr_q.lo_data;
  assign mem_lo_chk       = wr_q.lo_chk;
  assign mem_hi_data      = wr_q.hi_data;
  assign mem_hi_chk       = wr_q.hi_chk;

  // R2: decoded data follows memory data by exactly one cycle
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT && mem_rvalid) |=> rd_valid);

  // R5: the counter moves only after a correction
  p_count_on_corr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_count != $past(corr_count)) |-> $past(corr_event));

  // R6: a word is never both repaired and uncorrectable
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_corrected && rd_uncorrectable));

  // R7: a refused request never reaches memory
  p_refuse_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused |-> !mem_req);

  // R9: parity errors never count as corrections
  p_parity_no_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    par_event |=> $stable(corr_count));

  // R11: no memory write follows an uncorrectable read phase
  p_no_write_after_ded_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ded_event |=> !mem_req);
endmodule

// File: tb/paired_ecc_ctrl_test.sv
`timescale 1ns/1ps
module paired_ecc_ctrl_test;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ecc_mode, host_req, host_we;
  logic [AW-1:0] host_addr;
  logic [7:0] host_be;
  logic [63:0] host_wdata;
  logic host_ready, rd_valid, rd_corrected, rd_uncorrectable, parity_nmi, req_refused;
  logic [63:0] rd_data;
  logic [15:0] corr_count;
  logic [AW-1:0] corr_addr;
  logic [3:0] pair_retired;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_lo_data, mem_hi_data, mem_lo_rdata, mem_hi_rdata;
  logic [3:0] mem_lo_chk, mem_hi_chk, mem_lo_rchk, mem_hi_rchk;
  logic mem_rvalid;

  paired_ecc_ctrl uut (.*);

  // memory model, layout {hi_chk, hi_data, lo_chk, lo_data}
  logic [71:0] mem [0:1023];
  int rd_cnt, wr_cnt;
  logic flip_go;
  logic [AW-1:0] flip_addr;
  logic [71:0] flip_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
      mem_rvalid <= 1'b0;
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (flip_go) mem[flip_addr] <= mem[flip_addr] ^ flip_mask;
      if (mem_req) begin
        if (mem_we) begin
          mem[mem_addr] <= {mem_hi_chk, mem_hi_data, mem_lo_chk, mem_lo_data};
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rvalid <= 1'b1;
          {mem_hi_rchk, mem_hi_rdata, mem_lo_rchk, mem_lo_rdata} <= mem[mem_addr];
          rd_cnt <= rd_cnt + 1;
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent encoder: build the codeword by position, then fold
  function automatic logic [7:0] ref_check(input logic [63:0] d);
    logic [71:0] cw;
    logic [6:0] pp, c;
    int n;
    cw = '0;
    n = 0;
    for (int p = 1; p < 72; p++) begin
      pp = 7'(p);
      if ($countones(pp) != 1) begin
        cw[p] = d[n];
        n++;
      end
    end
    c = '0;
    for (int i = 0; i < 7; i++)
      for (int p = 1; p < 72; p++) begin
        pp = 7'(p);
        if (pp[i]) c[i] = c[i] ^ cw[p];
      end
    return {(^d) ^ (^c), c};
  endfunction

  function automatic logic [71:0] ref_word(input logic [63:0] d, input logic ecc);
    logic [7:0] c;
    logic [3:0] pl, ph;
    c = ref_check(d);
    for (int b = 0; b < 4; b++) begin
      pl[b] = ^d[8*b +: 8];
      ph[b] = ^d[32 + 8*b +: 8];
    end
    return ecc ? {c[7:4], d[63:32], c[3:0], d[31:0]} : {ph, d[63:32], pl, d[31:0]};
  endfunction

  function automatic logic [71:0] dbit(input int b);
    logic [71:0] m = '0;
    if (b < 32) m[b] = 1'b1; else m[b + 4] = 1'b1;
    return m;
  endfunction

  function automatic logic [71:0] cbit(input int c);
    logic [71:0] m = '0;
    if (c < 4) m[32 + c] = 1'b1; else m[68 + c - 4] = 1'b1;
    return m;
  endfunction

  task automatic flip(input logic [AW-1:0] a, input logic [71:0] m);
    @(negedge clk);
    flip_addr = a;
    flip_mask = m;
    flip_go = 1'b1;
    @(negedge clk);
    flip_go = 1'b0;
  endtask

  // results of one access
  logic saw_valid, saw_corr, saw_unc, saw_nmi, saw_ref;
  logic [63:0] got_data;
  int lat, d_rd, d_wr;

  task automatic access(input logic we, input logic [AW-1:0] a,
                        input logic [7:0] be, input logic [63:0] wd);
    int v_idx, r_idx, rd0, wr0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    saw_valid = 0; saw_corr = 0; saw_unc = 0; saw_nmi = 0; saw_ref = 0;
    got_data = '0; v_idx = -1; r_idx = -1;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      host_req = 1'b0;
      if (mem_rvalid && v_idx < 0) v_idx = i;
      if (rd_valid && !saw_valid) begin got_data = rd_data; r_idx = i; end
      saw_valid |= rd_valid;
      saw_corr  |= rd_corrected;
      saw_unc   |= rd_uncorrectable;
      saw_nmi   |= parity_nmi;
      saw_ref   |= req_refused;
    end
    lat = r_idx - v_idx;
    d_rd = rd_cnt - rd0;
    d_wr = wr_cnt - wr0;
  endtask

  localparam logic [63:0] D0 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] D1 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] D2 = 64'hA5A5_0F0F_3C3C_9669;
  localparam logic [63:0] D3 = 64'h0000_0001_8000_0000;
  localparam logic [63:0] D4 = 64'h1357_9BDF_2468_ACE0;

  task automatic t_reset();
    check("R10", "host_ready", 72'(host_ready), 72'd1);
    check("R10", "corr_count", 72'(corr_count), 72'd0);
    check("R10", "pair_retired", 72'(pair_retired), 72'd0);
    check("R10", "rd_valid/refused/mem_req", 72'({rd_valid, req_refused, mem_req}), 72'd0);
  endtask

  task automatic t_full_write();
    access(1'b1, 10'h005, 8'hFF, D0);
    check("R1", "write count", 72'(d_wr), 72'd1);
    check("R1", "stored word", mem[10'h005], ref_word(D0, 1'b1));
    access(1'b1, 10'h0C3, 8'hFF, D1);
    check("R1", "stored word 2", mem[10'h0C3], ref_word(D1, 1'b1));
  endtask

  task automatic t_clean_read();
    access(1'b0, 10'h005, 8'h00, '0);
    check("R2", "data", 72'(got_data), 72'(D0));
    check("R2", "flags", 72'({saw_valid, saw_corr, saw_unc, saw_nmi}), 72'b1000);
    check("R2", "latency", 72'(lat), 72'd1);
  endtask

  task automatic t_single_data();
    flip(10'h005, dbit(0));
    access(1'b0, 10'h005, 8'h00, '0);
    check("R3", "bit0 data", 72'(got_data), 72'(D0));
    check("R3", "bit0 corrected", 72'({saw_valid, saw_corr, saw_unc}), 72'b110);
    check("R5", "count 1", 72'(corr_count), 72'd1);
    check("R5", "addr 1", 72'(corr_addr), 72'h005);
    flip(10'h0C3, dbit(63));
    access(1'b0, 10'h0C3, 8'h00, '0);
    check("R3", "bit63 data", 72'(got_data), 72'(D1));
    check("R3", "bit63 corrected", 72'(saw_corr), 72'd1);
    check("R5", "count 2", 72'(corr_count), 72'd2);
    check("R5", "addr 2", 72'(corr_addr), 72'h0C3);
  endtask

  task automatic t_single_check();
    access(1'b1, 10'h031, 8'hFF, D2);
    flip(10'h031, cbit(7));
    access(1'b0, 10'h031, 8'h00, '0);
    check("R4", "overall bit data", 72'(got_data), 72'(D2));
    check("R4", "overall bit flags", 72'({saw_corr, saw_unc}), 72'b10);
    access(1'b1, 10'h032, 8'hFF, D3);
    flip(10'h032, cbit(2));
    access(1'b0, 10'h032, 8'h00, '0);
    check("R4", "check bit 2 data", 72'(got_data), 72'(D3));
    check("R4", "check bit 2 corrected", 72'(saw_corr), 72'd1);
    check("R5", "count 4", 72'(corr_count), 72'd4);
  endtask

  task automatic t_partial_write();
    logic [63:0] exp;
    exp = {D0[63:32], 32'hAAAA_5555};
    access(1'b1, 10'h005, 8'h0F, 64'hFFFF_FFFF_AAAA_5555);
    check("R8", "rmw accesses", 72'({d_rd[3:0], d_wr[3:0]}), 72'h11);
    check("R8", "merged word", mem[10'h005], ref_word(exp, 1'b1));
    check("R5", "rmw correction counted", 72'(corr_count), 72'd5);
    access(1'b0, 10'h005, 8'h00, '0);
    check("R8", "read back", 72'(got_data), 72'(exp));
    check("R8", "read back clean", 72'(saw_corr), 72'd0);
  endtask

  task automatic t_double();
    access(1'b1, 10'h140, 8'hFF, D4);
    flip(10'h140, dbit(3) | dbit(50));
    access(1'b0, 10'h140, 8'h00, '0);
    check("R6", "flags", 72'({saw_valid, saw_corr, saw_unc}), 72'b101);
    check("R6", "count unchanged", 72'(corr_count), 72'd5);
    check("R7", "pair 1 retired", 72'(pair_retired), 72'b0010);
    access(1'b0, 10'h1FF, 8'h00, '0);
    check("R7", "refused", 72'({saw_ref, saw_valid}), 72'b10);
    check("R7", "no memory access", 72'(d_rd + d_wr), 72'd0);
    access(1'b0, 10'h0C3, 8'h00, '0);
    check("R7", "pair 0 still served", 72'({saw_ref, saw_valid}), 72'b01);
    check("R7", "pair 0 data", 72'(got_data), 72'(D1));
  endtask

  task automatic t_rmw_double();
    access(1'b1, 10'h250, 8'hFF, D2);
    flip(10'h250, dbit(10) | dbit(40));
    access(1'b1, 10'h250, 8'h01, 64'h77);
    check("R11", "no write", 72'(d_wr), 72'd0);
    check("R11", "unc without valid", 72'({saw_unc, saw_valid}), 72'b10);
    check("R11", "pair 2 retired", 72'(pair_retired), 72'b0110);
  endtask

  task automatic t_parity();
    ecc_mode = 1'b0;
    access(1'b1, 10'h0AA, 8'hFF, D4);
    check("R9", "parity word", mem[10'h0AA], ref_word(D4, 1'b0));
    access(1'b0, 10'h0AA, 8'h00, '0);
    check("R9", "clean parity read", 72'({saw_valid, saw_nmi}), 72'b10);
    flip(10'h0AA, dbit(17));
    access(1'b0, 10'h0AA, 8'h00, '0);
    check("R9", "nmi", 72'({saw_valid, saw_nmi, saw_corr}), 72'b110);
    check("R9", "raw data", 72'(got_data), 72'(D4 ^ (64'd1 << 17)));
    check("R9", "count unchanged", 72'(corr_count), 72'd5);
    ecc_mode = 1'b1;
  endtask

  initial begin
    ecc_mode = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_be = '0; host_wdata = '0; flip_go = 1'b0; flip_addr = '0; flip_mask = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_clean_read();
    t_single_data();
    t_single_check();
    t_partial_write();
    t_parity();
    t_double();
    t_rmw_double();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule